// File: doc/BRIEF.md
# DS3 Nibble-Parallel Transmit Payload Serializer

This block takes DS3 payload from system-side equipment four bits at a time and turns it into a serial stream at the line bit clock rate. It generates a gapped nibble clock from the bit clock. Every frame of 4760 bit slots contains 56 overhead slots that carry no payload. The nibble clock skips these slots by stretching one period in every 21 from four bit clocks to five. The block supplies the serial payload bit, a strobe that marks each overhead slot, a frame-start flag and the current bit position. Later stages fill in the overhead bit values.

The block is a frame slave. It runs freely over a 4760-slot frame. When the frame reference input rises, it restarts at position zero. A nibble is taken on the third bit-clock edge after each rising edge of the nibble clock. It is shifted out, most significant bit first, in the payload slots of the next nibble period. This gives one nibble period of latency.

The nibble input follows a valid/ready handshake. `nib_ready` is high for exactly one bit-clock cycle in each nibble period. The source cannot stall the block. If `nib_valid` is low in that cycle, an all-zero nibble takes the place of the missing data. The block never waits for the source.

Top module: `ds3_nib_tx`

## Requirements
- R1: `bit_pos` counts 0 to 4759 and wraps to 0 when no realignment occurs; `frame_start` is 1 exactly when `bit_pos` is 0; the reset state is `bit_pos` = 0.
- R2: `oh_strobe` is 1 exactly in the cycles where `bit_pos` mod 85 equals 0 (56 cycles per frame) and 0 otherwise.
- R3: The nibble clock has 1176 rising edges per frame. A period starts at offsets 0, 5, 9, 13, ..., 81 within each 85-slot group. The period that begins at offset 0 (the overhead slot) lasts 5 cycles and the other 20 last 4 cycles. `nib_clk` is 1 in the first two cycles of each period and 0 in the rest.
- R4: `nib_ready` is 1 only in the third cycle of each nibble period (cycle index 2, counting from 0 at the nibble clock rise). The nibble is therefore taken on the third bit-clock edge after that rise.
- R5: A nibble accepted with `nib_valid`=1 and `nib_ready`=1 appears on `ser_bit` in the four payload slots of the following nibble period, bit 3 first and bit 0 last.
- R6: If `nib_valid` is 0 in a `nib_ready` cycle, four zero bits are sent in the following period and the position sequence does not change.
- R7: `ser_bit` is 0 in every overhead slot.
- R8: A rising edge of `frame_ref` (1 in this cycle, 0 in the previous cycle, or 1 in the first cycle after reset) makes `bit_pos` 0 in the next cycle and starts a new long nibble period there. Holding `frame_ref` high does not realign again.
- R9: `oh_nib_ind` is always 0, because no overhead nibble ever crosses the nibble interface.
- R10: While `rst_n` is low: `bit_pos` is 0, `frame_start` is 1, `oh_strobe` is 1, `nib_clk` is 1, `nib_ready` is 0 and `ser_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_ref | input | 1 | Frame reference; a rising edge restarts the frame |
| nib_data | input | 4 | Payload nibble, bit 3 sent first |
| nib_valid | input | 1 | Source has a nibble on `nib_data` |
| nib_ready | output | 1 | Capture cycle; handshake completes when `nib_valid` is also 1 |
| nib_clk | output | 1 | Gapped nibble clock |
| ser_bit | output | 1 | Serial payload bit, 0 in overhead slots |
| oh_strobe | output | 1 | High for the single overhead slot of each group |
| frame_start | output | 1 | High in the cycle where `bit_pos` is 0 |
| bit_pos | output | 13 | Bit position within the frame |
| oh_nib_ind | output | 1 | Overhead-nibble indicator, held inactive |

## Verification
The bench counts nibble clock rises and period lengths over a whole frame. A plain divide-by-four clock would give 1190 rises and no five-cycle periods. A stretch placed on the wrong period would shift the `nib_ready` cycle onto an overhead slot or skew the offsets of the group. The bench realigns in the middle of a frame and then holds the reference high. A design that triggers on the level instead of the edge would pin `bit_pos` at zero, and one that forgets to reload the shifter on realignment would send stale bits. The bench also starves the source and expects zero-filled nibbles. Every cycle it checks that overhead slots carry a zero, so a shifter that advances through the overhead slot would leak a payload bit there.

// File: rtl/ds3_nib_pkg.sv
package ds3_nib_pkg;
  // Per-cycle slot attributes decoded from the frame counters
  typedef struct packed {
    logic oh;    // overhead slot
    logic pay;   // payload slot
    logic nclk;  // nibble clock level
    logic cap;   // capture cycle
  } slot_t;
endpackage

// File: rtl/ds3_frame_timer.sv
module ds3_frame_timer #(
  parameter int PAY_RUN = 84,
  parameter int GROUPS  = 56,
  parameter int NIB_W   = 4,
  localparam int GRP_LEN   = PAY_RUN + 1,
  localparam int FRAME_LEN = GRP_LEN * GROUPS,
  localparam int NIBS      = PAY_RUN / NIB_W,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int OFF_W     = $clog2(GRP_LEN),
  localparam int PH_W      = $clog2(NIB_W + 1),
  localparam int NIX_W     = $clog2(NIBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  output logic [POS_W-1:0] pos,
  output logic [OFF_W-1:0] off,
  output logic [PH_W-1:0]  ph,
  output logic [NIX_W-1:0] nidx,
  output logic             per_end
);
  logic [PH_W-1:0] ph_last;

  // the first period of a group also covers the overhead slot
  assign ph_last = (nidx == '0) ? PH_W'(NIB_W) : PH_W'(NIB_W - 1);
  assign per_end = (ph == ph_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      off  <= '0;
      ph   <= '0;
      nidx <= '0;
    end else if (realign) begin
      pos  <= '0;
      off  <= '0;
      ph   <= '0;
      nidx <= '0;
    end else begin
      pos <= (pos == POS_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
      off <= (off == OFF_W'(GRP_LEN - 1)) ? '0 : off + 1'b1;
      if (per_end) begin
        ph   <= '0;
        nidx <= (nidx == NIX_W'(NIBS - 1)) ? '0 : nidx + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  AST_FRAME_GRP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |-> (off == '0)); // R1
  AST_GRP_NIB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (off == '0) |-> (ph == '0 && nidx == '0)); // R3
endmodule

// File: rtl/ds3_slot_decode.sv
module ds3_slot_decode
  import ds3_nib_pkg::*;
#(
  parameter int PAY_RUN = 84,
  parameter int NIB_W   = 4,
  localparam int GRP_LEN = PAY_RUN + 1,
  localparam int NIBS    = PAY_RUN / NIB_W,
  localparam int OFF_W   = $clog2(GRP_LEN),
  localparam int PH_W    = $clog2(NIB_W + 1),
  localparam int NIX_W   = $clog2(NIBS)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [PH_W-1:0]  ph,
  input  logic [NIX_W-1:0] nidx,
  output slot_t            slot
);
  logic unused_nidx;
  assign unused_nidx = ^nidx;

  always_comb begin
    slot.oh   = (off == '0);
    slot.pay  = (off != '0);
    slot.nclk = (ph < PH_W'(2));
    slot.cap  = (ph == PH_W'(2));
  end
endmodule

// File: rtl/ds3_nib_serializer.sv
module ds3_nib_serializer #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_data,
  input  logic             load,
  input  logic             pay,
  output logic             ser
);
  logic [NIB_W-1:0] hold;
  logic [NIB_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      sh   <= '0;
    end else begin
      if (cap) hold <= in_valid ? in_data : '0;
      if (load)     sh <= hold;
      else if (pay) sh <= {sh[NIB_W-2:0], 1'b0};
    end
  end

  assign ser = pay & sh[NIB_W-1];

  AST_STARVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !in_valid) |=> (hold == '0)); // R6
endmodule

// File: rtl/ds3_nib_tx.sv
module ds3_nib_tx
  import ds3_nib_pkg::*;
#(
  parameter int PAY_RUN = 84,
  parameter int GROUPS  = 56,
  parameter int NIB_W   = 4,
  localparam int GRP_LEN   = PAY_RUN + 1,
  localparam int FRAME_LEN = GRP_LEN * GROUPS,
  localparam int NIBS      = PAY_RUN / NIB_W,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int OFF_W     = $clog2(GRP_LEN),
  localparam int PH_W      = $clog2(NIB_W + 1),
  localparam int NIX_W     = $clog2(NIBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ref,
  input  logic [NIB_W-1:0] nib_data,
  input  logic             nib_valid,
  output logic             nib_ready,
  output logic             nib_clk,
  output logic             ser_bit,
  output logic             oh_strobe,
  output logic             frame_start,
  output logic [POS_W-1:0] bit_pos,
  output logic             oh_nib_ind
);
  logic             ref_q;
  logic             realign;
  logic [OFF_W-1:0] off;
  logic [PH_W-1:0]  ph;
  logic [NIX_W-1:0] nidx;
  logic             per_end;
  slot_t            slot;

  // reference is synchronous to the bit clock; edge detect only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= frame_ref;
  end
  assign realign = frame_ref & ~ref_q;

  ds3_frame_timer #(.PAY_RUN(PAY_RUN), .GROUPS(GROUPS), .NIB_W(NIB_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .realign(realign),
    .pos(bit_pos), .off(off), .ph(ph), .nidx(nidx), .per_end(per_end)
  );

  ds3_slot_decode #(.PAY_RUN(PAY_RUN), .NIB_W(NIB_W)) u_dec (
    .off(off), .ph(ph), .nidx(nidx), .slot(slot)
  );

  ds3_nib_serializer #(.NIB_W(NIB_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .cap(slot.cap), .in_valid(nib_valid),
    .in_data(nib_data), .load(per_end | realign), .pay(slot.pay), .ser(ser_bit)
  );

  assign nib_ready   = slot.cap;
  assign nib_clk     = slot.nclk;
  assign oh_strobe   = slot.oh;
  assign frame_start = (bit_pos == '0);
  assign oh_nib_ind  = 1'b0;

  AST_OH_SER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    oh_strobe |-> !ser_bit); // R7
  AST_OH_IN_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    oh_strobe |-> nib_clk); // R3
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    nib_ready |-> (!nib_clk && !oh_strobe)); // R4
  AST_REALIGN_START: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (frame_start && oh_strobe)); // R8
endmodule

// File: tb/sim_ds3_nib_tx.sv
`timescale 1ns/1ps
module sim_ds3_nib_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_ref = 1'b0;
  logic [3:0] nib_data = '0;
  logic nib_valid = 1'b0;
  logic nib_ready, nib_clk, ser_bit, oh_strobe, frame_start, oh_nib_ind;
  logic [12:0] bit_pos;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int m_pos = 0;
  bit m_prev = 0;
  logic [3:0] m_hold = '0;
  logic [3:0] m_sh = '0;
  logic [3:0] dpat = 4'h3;
  string ser_tag = "R5";
  // last observed outputs
  logic o_nclk;
  logic [12:0] o_pos;

  always #2.5 clk = ~clk;

  ds3_nib_tx u0 (
    .clk(clk), .rst_n(rst_n), .frame_ref(frame_ref), .nib_data(nib_data),
    .nib_valid(nib_valid), .nib_ready(nib_ready), .nib_clk(nib_clk),
    .ser_bit(ser_bit), .oh_strobe(oh_strobe), .frame_start(frame_start),
    .bit_pos(bit_pos), .oh_nib_ind(oh_nib_ind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (model pos %0d)", tag, act, exp, m_pos);
    end
  endtask

  function automatic int m_off();
    return m_pos % 85;
  endfunction

  function automatic int m_ph();
    int o = m_off();
    return (o < 5) ? o : (o - 5) % 4;
  endfunction

  task automatic check_now();
    int o = m_off();
    int p = m_ph();
    chk("R1 bit_pos", int'(bit_pos), m_pos);
    chk("R1 frame_start", int'(frame_start), int'(m_pos == 0));
    chk("R2 oh_strobe", int'(oh_strobe), int'(o == 0));
    chk("R3 nib_clk", int'(nib_clk), int'(p < 2));
    chk("R4 nib_ready", int'(nib_ready), int'(p == 2));
    if (o == 0) chk("R7 ser_bit in overhead", int'(ser_bit), 0);
    else        chk({ser_tag, " ser_bit"}, int'(ser_bit), int'(m_sh[3]));
    chk("R9 oh_nib_ind", int'(oh_nib_ind), 0);
    o_nclk = nib_clk;
    o_pos  = bit_pos;
  endtask

  task automatic model_step(input bit fr, input bit v, input logic [3:0] d);
    int o = m_off();
    int p = m_ph();
    bit rise = fr && !m_prev;
    bit pend = (o < 5) ? (o == 4) : (p == 3);
    logic [3:0] nsh;
    if (pend || rise) nsh = m_hold;
    else if (o != 0)  nsh = {m_sh[2:0], 1'b0};
    else              nsh = m_sh;
    if (p == 2) m_hold = v ? d : 4'h0;
    m_sh = nsh;
    m_pos = rise ? 0 : (m_pos + 1) % 4760;
    m_prev = fr;
  endtask

  // one bit-clock cycle: check the present state, then drive the inputs
  task automatic cyc(input bit fr, input bit v);
    @(negedge clk);
    check_now();
    dpat = dpat * 4'd5 + 4'd3;
    frame_ref = fr;
    nib_valid = v;
    nib_data  = dpat;
    model_step(fr, v, dpat);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 bit_pos", int'(bit_pos), 0);
    chk("R10 frame_start", int'(frame_start), 1);
    chk("R10 oh_strobe", int'(oh_strobe), 1);
    chk("R10 nib_clk", int'(nib_clk), 1);
    chk("R10 nib_ready", int'(nib_ready), 0);
    chk("R10 ser_bit", int'(ser_bit), 0);
    m_pos = 0; m_prev = 0; m_hold = '0; m_sh = '0;
    rst_n = 1'b1;
    frame_ref = 1'b0; nib_valid = 1'b0; nib_data = '0;
    model_step(1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_freerun();
    int rises = 0, fives = 0, fours = 0, last = -1;
    bit prev = 1'b0;
    ser_tag = "R5";
    while (m_pos != 0) cyc(1'b0, 1'b1);
    for (int i = 0; i < 4761; i++) begin
      cyc(1'b0, 1'b1);
      if (o_nclk && !prev) begin
        if (i < 4760) rises++;
        if (last >= 0) begin
          if (i - last == 5) fives++;
          else if (i - last == 4) fours++;
        end
        last = i;
      end
      prev = o_nclk;
    end
    chk("R3 nibble clock rises per frame", rises, 1176);
    chk("R3 five-cycle periods", fives, 56);
    chk("R3 four-cycle periods", fours, 1120);
    chk("R1 wrap to zero", int'(o_pos), 0);
    repeat (4000) cyc(1'b0, 1'b1);
  endtask

  task automatic t_realign();
    ser_tag = "R5";
    while (m_pos != 1003) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    chk("R8 realign to zero", int'(o_pos), 0);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    repeat (200) cyc(1'b0, 1'b1);
    chk("R8 runs on after realign", int'(o_pos), 202);
  endtask

  task automatic t_hold_high();
    ser_tag = "R5";
    while (m_pos != 77) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    repeat (300) cyc(1'b1, 1'b1);
    chk("R8 level does not realign", int'(o_pos), 299);
    repeat (20) cyc(1'b0, 1'b1);
  endtask

  task automatic t_starve();
    int ones = 0;
    while (m_pos != 2000) cyc(1'b0, 1'b1);
    ser_tag = "R6";
    repeat (60) cyc(1'b0, 1'b0);
    // payload of starved periods must be zero
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 1'b0);
      if (ser_bit) ones++;
    end
    chk("R6 starved stream zero", ones, 0);
    ser_tag = "R5";
    repeat (300) cyc(1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_freerun();
    t_realign();
    t_hold_high();
    t_starve();
    t_reset();
    repeat (100) cyc(1'b0, 1'b1);
    finish_run();
  end
endmodule